// File: doc/BRIEF.md
# Program Sequencer with Delay Slot and Hardware Loops

This block steps a small signal processor through its program store. It keeps a program counter, a loop-top register, a loop counter, a one-entry delay register and a running flag. It issues one instruction word per clock while running. It decodes the class of each word and evaluates branch conditions against four flag inputs: zero, sign, carry and a timer flag. From these it decides the next fetch address.

Every redirect of the program flow (a taken jump, a loop back-edge, a write to the program counter) lets the instruction at the next sequential address run first. Execution then continues at the new address. Two loop forms exist. The back-edge form returns to the loop-top register. The repeat form sends control back to the loop instruction itself, so the single word after it runs once more on each pass. An end instruction stops fetching and can raise a one-clock interrupt. A word of the reserved class stops fetching and raises an error flag.

The arithmetic and data-movement units read the issued word from the program store themselves. The sequencer only drives the address and the valid strobe.

Top module: `prog_sequencer`

## Requirements
- R1: After reset, `issue_valid`, `end_irq` and `illegal_err` are 0 and no instruction issues. A `start` pulse while idle loads `start_pc`, and the word at that address issues in the following cycle.
- R2: While running, exactly one word issues per clock. Without a redirect, each issued address is the previous one plus 1.
- R3: Word bits 31:30 give the class: 00 operation, 01 reserved, 10 move-immediate, 11 control. For class 11, bits 29:28 give DMA (00), jump (01), loop (10) or end (11). Operation and DMA words only advance the counter.
- R4: A jump whose 7-bit condition field (bits 25:19) is all zero is always taken, and its target is bits 7:0. On a taken jump, the word at the jump's address plus 1 issues next, and then the word at the target.
- R5: The low 4 bits of the condition field select zero (1), sign (2), zero or sign (3), carry (4) or timer flag (8). Field bit 5 (word bit 24) set means the test is true when the selected flag is set. Bit 5 clear inverts the test.
- R6: A loop word with bit 27 clear, seen with a nonzero loop counter, decrements the counter and branches to the loop-top register, with one delay slot.
- R7: A loop word with bit 27 set, seen with a nonzero loop counter, decrements the counter. The word after it runs, and control then comes back to the loop word.
- R8: A move-immediate to destination 0xC (bits 29:26) writes the program counter with one delay slot. It also stores the address after the move into the loop-top register. Destination 0xA loads the loop counter and 0xB loads the loop top. With bit 25 set, the move applies only when the condition field passes, and the value is a signed 19-bit field. With bit 25 clear, it always applies, and the value is a signed 25-bit field.
- R9: A loop word seen with a zero counter falls through, and the counter stays at zero (it never wraps).
- R10: An end word clears the running state, and no further word issues. With bit 27 set, `end_irq` is high for exactly one clock, in the cycle after the end word. With bit 27 clear, `end_irq` stays low.
- R11: A reserved-class word stops execution, and `illegal_err` rises in the next cycle. The flag stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution when idle |
| start_pc | input | 8 | First fetch address |
| imem_addr | output | 8 | Program store read address |
| imem_rdata | input | 32 | Word at `imem_addr`, same cycle |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_c | input | 1 | Carry flag |
| flag_t0 | input | 1 | Timer flag |
| issue_valid | output | 1 | The word at `imem_addr` executes this cycle |
| end_irq | output | 1 | One-clock pulse after an end word with interrupt |
| illegal_err | output | 1 | Set by a reserved-class word |

## Verification
The hardest states to reach are the nested cases of the loop and redirect logic. One is the repeat-form loop, whose delay-slot word must run between passes of the loop word. Another is the counter reaching zero and then meeting a second back-edge, which must not wrap. A third is the loop-top register being filled indirectly by a program-counter write rather than by a load. Short programs placed in a bench-owned store reach each of these from the ports. Each program first loads the counter through move-immediate words. It then runs until the end word, and the full issued-address trace is compared with a trace derived from the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_W = 32;

    localparam logic [3:0] DST_LOOPCNT = 4'hA;
    localparam logic [3:0] DST_LOOPTOP = 4'hB;
    localparam logic [3:0] DST_PC      = 4'hC;

    typedef enum logic [2:0] {
        K_OP, K_BAD, K_MVI, K_DMA, K_JMP, K_LOOP, K_END
    } iclass_t;

    typedef struct packed {
        iclass_t             cls;
        logic [6:0]          cond;
        logic                cond_on;
        logic                alt;
        logic [3:0]          dest;
        logic [WORD_W-1:0]   imm;
    } dec_t;

    function automatic logic cond_pass(input logic [6:0] c,
                                       input logic z, input logic s,
                                       input logic cy, input logic t0);
        logic r;
        case (c[3:0])
            4'h1:    r = z;
            4'h2:    r = s;
            4'h3:    r = z | s;
            4'h4:    r = cy;
            4'h8:    r = t0;
            default: r = 1'b0;
        endcase
        return c[5] ? r : ~r;
    endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec.cond    = word[25:19];
        dec.alt     = word[27];
        dec.dest    = word[29:26];
        dec.cond_on = 1'b0;
        dec.imm     = '0;
        dec.cls     = K_OP;
        case (word[31:30])
            2'b00: dec.cls = K_OP;
            2'b01: dec.cls = K_BAD;
            2'b10: begin
                dec.cls     = K_MVI;
                dec.cond_on = word[25];
                if (word[25])
                    dec.imm = {{(WORD_W-19){word[18]}}, word[18:0]};
                else
                    dec.imm = {{(WORD_W-25){word[24]}}, word[24:0]};
            end
            default: begin
                dec.imm = {{(WORD_W-8){1'b0}}, word[7:0]};
                case (word[29:28])
                    2'b00:   dec.cls = K_DMA;
                    2'b01:   dec.cls = K_JMP;
                    2'b10:   dec.cls = K_LOOP;
                    default: dec.cls = K_END;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/seq_loop_regs.sv
module seq_loop_regs #(
    parameter int PC_W   = 8,
    parameter int LOOP_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_cnt,
    input  logic [LOOP_W-1:0] cnt_val,
    input  logic              dec_cnt,
    input  logic              ld_top,
    input  logic [PC_W-1:0]   top_val,
    output logic [LOOP_W-1:0] cnt,
    output logic [PC_W-1:0]   top,
    output logic              cnt_nz
);
    localparam logic [LOOP_W-1:0] ONE = {{(LOOP_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            top <= '0;
        end else begin
            if (ld_cnt)
                cnt <= cnt_val;
            else if (dec_cnt)
                cnt <= cnt - ONE;
            if (ld_top)
                top <= top_val;
        end
    end

    assign cnt_nz = (cnt != '0);

    // R9: the counter is never decremented from zero
    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        dec_cnt |-> cnt != '0);

    // R6 / R7: a decrement lowers the count by exactly one
    assert_dec_step_R6: assert property (@(posedge clk) disable iff (rst)
        (dec_cnt && !ld_cnt) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int PC_W   = 8,
    parameter int LOOP_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W-1:0]   start_pc,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    input  logic              flag_z,
    input  logic              flag_s,
    input  logic              flag_c,
    input  logic              flag_t0,
    output logic              issue_valid,
    output logic              end_irq,
    output logic              illegal_err
);
    localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] pc, dly, fetch, seq, tgt, top_val, loop_top;
    logic            dly_v, running;
    logic            redirect, stop, irq_set, bad;
    logic            ld_cnt, ld_top, dec_cnt, cnt_nz, hit;
    logic [LOOP_W-1:0] cnt;
    dec_t            dec;

    seq_decode u_dec (.word(imem_rdata), .dec(dec));

    seq_loop_regs #(.PC_W(PC_W), .LOOP_W(LOOP_W)) u_loop (
        .clk(clk), .rst(rst),
        .ld_cnt(ld_cnt), .cnt_val(dec.imm[LOOP_W-1:0]),
        .dec_cnt(dec_cnt),
        .ld_top(ld_top), .top_val(top_val),
        .cnt(cnt), .top(loop_top), .cnt_nz(cnt_nz)
    );

    // Fetch comes from the delay register first, then the counter.
    assign fetch = dly_v ? dly : pc;
    assign seq   = dly_v ? pc : pc + PC_ONE;
    assign hit   = cond_pass(dec.cond, flag_z, flag_s, flag_c, flag_t0);

    always_comb begin
        redirect = 1'b0;
        tgt      = seq;
        stop     = 1'b0;
        irq_set  = 1'b0;
        bad      = 1'b0;
        ld_cnt   = 1'b0;
        ld_top   = 1'b0;
        top_val  = dec.imm[PC_W-1:0];
        dec_cnt  = 1'b0;
        if (running) begin
            case (dec.cls)
                K_JMP: begin
                    if (dec.cond == 7'd0 || hit) begin
                        redirect = 1'b1;
                        tgt      = dec.imm[PC_W-1:0];
                    end
                end
                K_LOOP: begin
                    if (cnt_nz) begin
                        dec_cnt  = 1'b1;
                        redirect = 1'b1;
                        tgt      = dec.alt ? seq - PC_ONE : loop_top;
                    end
                end
                K_MVI: begin
                    if (!dec.cond_on || hit) begin
                        case (dec.dest)
                            DST_LOOPCNT: ld_cnt = 1'b1;
                            DST_LOOPTOP: ld_top = 1'b1;
                            DST_PC: begin
                                ld_top   = 1'b1;
                                top_val  = seq;
                                redirect = 1'b1;
                                tgt      = dec.imm[PC_W-1:0];
                            end
                            default: ;
                        endcase
                    end
                end
                K_END: begin
                    stop    = 1'b1;
                    irq_set = dec.alt;
                end
                K_BAD: begin
                    stop = 1'b1;
                    bad  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= '0;
            dly         <= '0;
            dly_v       <= 1'b0;
            running     <= 1'b0;
            end_irq     <= 1'b0;
            illegal_err <= 1'b0;
        end else begin
            end_irq <= 1'b0;
            if (!running) begin
                if (start) begin
                    running     <= 1'b1;
                    pc          <= start_pc;
                    dly_v       <= 1'b0;
                    illegal_err <= 1'b0;
                end
            end else if (stop) begin
                running <= 1'b0;
                dly_v   <= 1'b0;
                end_irq <= irq_set;
                if (bad)
                    illegal_err <= 1'b1;
            end else if (redirect) begin
                dly   <= seq;
                dly_v <= 1'b1;
                pc    <= tgt;
            end else begin
                pc    <= seq;
                dly_v <= 1'b0;
            end
        end
    end

    assign imem_addr   = fetch;
    assign issue_valid = running;

    // R4: after a redirect from a sequential fetch, the next address is the following one
    assert_delay_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && redirect && !dly_v) |=> issue_valid && imem_addr == $past(imem_addr) + PC_ONE);

    // R4: after the delay slot, the saved counter is fetched
    assert_after_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dly_v && !stop && !redirect) |=> imem_addr == $past(pc));

    // R10: an end word stops issue
    assert_end_stops_R10: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dec.cls == K_END) |=> !issue_valid);

    // R10: the interrupt lasts one clock
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        end_irq |=> !end_irq);

    // R11: a reserved word halts and flags
    assert_illegal_R11: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && dec.cls == K_BAD) |=> illegal_err && !issue_valid);
endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  start_pc;
    logic [7:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic        flag_z, flag_s, flag_c, flag_t0;
    logic        issue_valid, end_irq, illegal_err;

    logic [31:0] mem [0:255];
    int          total = 0;
    int          bad_n = 0;
    int          got [0:63];
    int          exp_t [0:63];
    int          got_n;
    int          irqs;

    always #4 clk = ~clk;

    assign imem_rdata = mem[imem_addr];

    prog_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_t0(flag_t0),
        .issue_valid(issue_valid), .end_irq(end_irq), .illegal_err(illegal_err)
    );

    function automatic logic [31:0] e_nop();
        return 32'h0;
    endfunction
    function automatic logic [31:0] e_jmp(input logic [6:0] c, input logic [7:0] t);
        return {4'b1101, 2'b00, c, 11'b0, t};
    endfunction
    function automatic logic [31:0] e_loop(input logic rn);
        return {4'b1110, rn, 27'b0};
    endfunction
    function automatic logic [31:0] e_end(input logic irq);
        return {4'b1111, irq, 27'b0};
    endfunction
    function automatic logic [31:0] e_mvi(input logic [3:0] d, input logic [24:0] v);
        return {2'b10, d, 1'b0, v};
    endfunction
    function automatic logic [31:0] e_mvic(input logic [3:0] d, input logic [5:0] c, input logic [18:0] v);
        return {2'b10, d, 1'b1, c, v};
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = e_end(1'b0);
    endtask

    task automatic set_flags(input logic z, input logic s, input logic c, input logic t);
        flag_z = z; flag_s = s; flag_c = c; flag_t0 = t;
    endtask

    task automatic run(input logic [7:0] sp);
        @(negedge clk);
        start = 1'b1;
        start_pc = sp;
        @(negedge clk);
        start = 1'b0;
        got_n = 0;
        irqs = 0;
        for (int k = 0; k < 64; k++) begin
            if (issue_valid) begin
                got[got_n] = int'(imem_addr);
                got_n++;
            end
            if (end_irq) irqs++;
            if (!issue_valid) break;
            @(negedge clk);
        end
        @(negedge clk);
        if (end_irq) irqs++;
    endtask

    task automatic cmp_trace(input string req, input int n);
        chk(got_n == n, {req, " trace length"}, got_n, n);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got[i] == exp_t[i], {req, " trace entry"}, got[i], exp_t[i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1 idle after reset", int'(issue_valid), 0);
        chk(end_irq == 1'b0, "R1 irq low after reset", int'(end_irq), 0);
        chk(illegal_err == 1'b0, "R1 err low after reset", int'(illegal_err), 0);
    endtask

    task automatic t_straight();
        clear_mem();
        mem[8'h10] = e_nop();
        mem[8'h11] = {2'b11, 2'b00, 28'h0};
        mem[8'h12] = e_nop();
        mem[8'h13] = e_end(1'b0);
        run(8'h10);
        exp_t[0] = 16; exp_t[1] = 17; exp_t[2] = 18; exp_t[3] = 19;
        cmp_trace("R2 R3 sequential", 4);
        chk(irqs == 0, "R10 plain end no irq", irqs, 0);
        chk(issue_valid == 1'b0, "R10 halted", int'(issue_valid), 0);
    endtask

    task automatic t_jump_uncond();
        clear_mem();
        mem[0] = e_jmp(7'h00, 8'd5);
        mem[1] = e_nop();
        mem[2] = e_nop();
        mem[5] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = 5;
        cmp_trace("R4 unconditional jump", 3);
    endtask

    task automatic t_cond(input logic [6:0] c, input logic z, input logic s,
                          input logic cy, input logic t, input logic taken);
        clear_mem();
        set_flags(z, s, cy, t);
        mem[0] = e_jmp(c, 8'd5);
        mem[1] = e_nop();
        mem[2] = e_end(1'b0);
        mem[5] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = taken ? 5 : 2;
        cmp_trace("R5 conditional jump", 3);
        set_flags(0, 0, 0, 0);
    endtask

    task automatic t_backedge();
        clear_mem();
        mem[0] = e_mvi(4'hA, 25'd2);
        mem[1] = e_mvi(4'hB, 25'd3);
        mem[2] = e_nop();
        mem[3] = e_nop();
        mem[4] = e_loop(1'b0);
        mem[5] = e_nop();
        mem[6] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = 2; exp_t[3] = 3; exp_t[4] = 4;
        exp_t[5] = 5; exp_t[6] = 3; exp_t[7] = 4; exp_t[8] = 5; exp_t[9] = 3;
        exp_t[10] = 4; exp_t[11] = 5; exp_t[12] = 6;
        cmp_trace("R6 back-edge loop", 13);
    endtask

    task automatic t_repeat();
        clear_mem();
        mem[0] = e_mvi(4'hA, 25'd2);
        mem[1] = e_loop(1'b1);
        mem[2] = e_nop();
        mem[3] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = 2; exp_t[3] = 1;
        exp_t[4] = 2; exp_t[5] = 1; exp_t[6] = 2; exp_t[7] = 3;
        cmp_trace("R7 repeat-next loop", 8);
    endtask

    task automatic t_pcwrite();
        clear_mem();
        mem[0] = e_mvi(4'hA, 25'd1);
        mem[1] = e_mvi(4'hC, 25'd6);
        mem[2] = e_nop();
        mem[3] = e_end(1'b0);
        mem[6] = e_loop(1'b0);
        mem[7] = e_nop();
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = 2; exp_t[3] = 6;
        exp_t[4] = 7; exp_t[5] = 2; exp_t[6] = 3;
        cmp_trace("R8 pc write saves loop top", 7);
    endtask

    task automatic t_cond_mvi(input logic z, input logic taken);
        clear_mem();
        set_flags(z, 0, 0, 0);
        mem[0] = e_mvic(4'hC, 6'h21, 19'd6);
        mem[1] = e_nop();
        mem[2] = e_end(1'b0);
        mem[6] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = taken ? 6 : 2;
        cmp_trace("R8 conditional move", 3);
        set_flags(0, 0, 0, 0);
    endtask

    task automatic t_zero_count();
        clear_mem();
        mem[0] = e_mvi(4'hA, 25'd0);
        mem[1] = e_mvi(4'hB, 25'd0);
        mem[2] = e_loop(1'b0);
        mem[3] = e_loop(1'b0);
        mem[4] = e_end(1'b0);
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1; exp_t[2] = 2; exp_t[3] = 3; exp_t[4] = 4;
        cmp_trace("R9 zero count falls through", 5);
    endtask

    task automatic t_end_irq();
        clear_mem();
        mem[0] = e_nop();
        mem[1] = e_end(1'b1);
        mem[2] = e_nop();
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1;
        cmp_trace("R10 end with interrupt", 2);
        chk(irqs == 1, "R10 irq one clock", irqs, 1);
    endtask

    task automatic t_illegal();
        clear_mem();
        mem[0] = e_nop();
        mem[1] = 32'h4000_0000;
        mem[2] = e_nop();
        run(8'd0);
        exp_t[0] = 0; exp_t[1] = 1;
        cmp_trace("R11 reserved word halts", 2);
        chk(illegal_err == 1'b1, "R11 err set", int'(illegal_err), 1);
        repeat (3) @(negedge clk);
        chk(illegal_err == 1'b1, "R11 err sticky", int'(illegal_err), 1);
        mem[1] = e_end(1'b0);
        run(8'd0);
        chk(illegal_err == 1'b0, "R1 R11 start clears err", int'(illegal_err), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        start_pc = 8'd0;
        set_flags(0, 0, 0, 0);
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_straight();
        t_jump_uncond();
        t_cond(7'h21, 1, 0, 0, 0, 1);
        t_cond(7'h21, 0, 0, 0, 0, 0);
        t_cond(7'h01, 0, 0, 0, 0, 1);
        t_cond(7'h22, 0, 1, 0, 0, 1);
        t_cond(7'h23, 0, 1, 0, 0, 1);
        t_cond(7'h23, 0, 0, 0, 0, 0);
        t_cond(7'h24, 0, 0, 1, 0, 1);
        t_cond(7'h04, 0, 0, 1, 0, 0);
        t_cond(7'h28, 0, 0, 0, 1, 1);
        t_cond(7'h08, 0, 0, 0, 0, 1);
        t_backedge();
        t_repeat();
        t_pcwrite();
        t_cond_mvi(1'b0, 1'b0);
        t_cond_mvi(1'b1, 1'b1);
        t_zero_count();
        t_end_irq();
        t_illegal();
        $display("test done: total=%0d bad=%0d", total, bad_n);
        $finish;
    end
endmodule